// File: doc/BRIEF.md
# Register-Tag Vector Issue Sequencer

This block sits between a scalar instruction decoder and the execution units. Each decoded instruction arrives with a destination and two source register numbers and an opaque operation field. The block looks up each of the three register numbers in a one-bit-per-register tag table. If none is tagged, the instruction passes through as a single micro-op. If at least one is tagged, the block repeats the instruction as a run of element micro-ops. The run length comes from a vector-length register. Every tagged operand steps to the next register number on each element. Untagged operands stay fixed.

While a run is in progress, the block accepts no new instruction and keeps the program counter still. It raises its PC-advance strobe only on the handshake of the final element. A destination of register zero marks the whole run as hints: no element writes a register, and each element carries the vector length so that downstream logic can read it as a parameter. The tag table and the length register are loaded through a small CSR write port. That port is only open between instructions.

Top module: `tagIssueSeq`

## Requirements
- R1: A CSR write with kind 0 sets the tag of register `csrWrIdx` to `csrWrData[0]`. A write with kind 1 loads `csrWrData` into the vector-length register. After reset all tags are clear and the vector length is 1.
- R2: If no operand of an accepted instruction is tagged, or the vector length is 0 or 1, exactly one micro-op is issued, with index 0 and the last flag set.
- R3: If at least one operand is tagged and the vector length is N ≥ 2, exactly N micro-ops are issued, with indices 0 to N-1. The last flag is set on the final one only.
- R4: In element i, a tagged operand carries (base register + i) modulo 32.
- R5: An untagged operand carries its base register number unchanged in every element.
- R6: `pcAdvance` is high only in the cycle in which the final micro-op of an instruction is handed over (`uopValid` and `uopReady` both high).
- R7: If rd is 0, every element has `uopHint`=1, `uopWrEn`=0 and `uopRd`=0. Otherwise `uopHint`=0 and `uopWrEn`=1. Every element carries the vector length captured at acceptance on `uopVl`, and the operation field unchanged on `uopOp`.
- R8: `inReady` is low from acceptance until the final element is handed over. The element index advances only on a cycle with `uopReady` high, and the outputs hold while `uopReady` is low.
- R9: CSR writes that arrive while a run is in progress are discarded. The tags and the length used by a run are those in force when its instruction was accepted.
- R10: `uopWrap` is high on an element exactly when some tagged operand's base + i exceeds 31. A destination of register 0 never contributes to `uopWrap`.
- R11: After reset, `inReady`=1, `uopValid`=0 and `pcAdvance`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Decoded instruction present |
| inReady | output | 1 | Block can accept an instruction |
| inOp | input | OP_W | Opaque operation field |
| inRd | input | 5 | Destination register |
| inRs1 | input | 5 | First source register |
| inRs2 | input | 5 | Second source register |
| csrWrEn | input | 1 | CSR write strobe |
| csrWrKind | input | 1 | 0 = tag entry, 1 = vector length |
| csrWrIdx | input | 5 | Register whose tag is written |
| csrWrData | input | VL_W | Tag bit in bit 0, or the vector length |
| uopValid | output | 1 | Micro-op present |
| uopReady | input | 1 | Downstream takes the micro-op |
| uopOp | output | OP_W | Operation field |
| uopRd | output | 5 | Element destination register |
| uopRs1 | output | 5 | Element first source |
| uopRs2 | output | 5 | Element second source |
| uopWrEn | output | 1 | Element writes its destination |
| uopHint | output | 1 | Element is a hint (rd was 0) |
| uopVl | output | VL_W | Vector length of the run |
| uopIdx | output | VL_W | Element index |
| uopLast | output | 1 | Final element of the run |
| uopWrap | output | 1 | A tagged register number wrapped past 31 |
| pcAdvance | output | 1 | Program counter may step |

## Verification
The sequencing is driven with a table of instructions that differ in which operands are tagged and in the vector length. The table includes no tags with a long length, a single tagged source, tags on rd and rs2 only, all three tagged, length 0 and length 1 with tags, and a destination of register 0. These cases separate per-operand stepping from stepping all operands together, and the length rule from the tag rule. Some entries start near register 31, so that modulo wrap and the wrap flag are checked on the exact elements where they occur. Each entry has its own downstream stall pattern, so a counter that advances without `uopReady` shows up as a skipped index or an early PC advance. Directed cases cover the reset defaults and a length write issued in the middle of a run, which must not change the next run.

// File: rtl/tagseq_pkg.sv
`timescale 1ns/1ps
package tagseq_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seqState_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;     // capture an accepted instruction
    logic step;     // hand over a non-final element
    logic finish;   // hand over the final element
    logic csrOpen;  // CSR writes may land this cycle
  } seqStrobes_t;

  localparam int NUM_OPERANDS = 3;  // rd, rs1, rs2

endpackage

// File: rtl/tagSeqCtrl.sv
`timescale 1ns/1ps
module tagSeqCtrl
  import tagseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        uopReady,
  input  logic        lastElem,
  output logic        inReady,
  output logic        uopValid,
  output logic        pcAdvance,
  output seqStrobes_t strobes
);

  seqState_t stateQ, stateD;
  logic busy;
  logic fire;

  always_comb begin
    busy           = (stateQ == SEQ_RUN);
    fire           = busy && uopReady;
    inReady        = !busy;
    uopValid       = busy;
    strobes.load    = !busy && inValid;
    strobes.step    = fire && !lastElem;
    strobes.finish  = fire && lastElem;
    strobes.csrOpen = !busy;
    pcAdvance      = strobes.finish;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      SEQ_IDLE: if (strobes.load)   stateD = SEQ_RUN;
      SEQ_RUN:  if (strobes.finish) stateD = SEQ_IDLE;
      default:  stateD = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= SEQ_IDLE;
    else       stateQ <= stateD;
  end

  // R6: the PC moves only with the final element's handshake
  a_r6_pc_on_last: assert property (@(posedge clk) disable iff (!rstN)
    pcAdvance |-> (uopValid && uopReady && lastElem));

  // R8: no new instruction while elements are outstanding
  a_r8_ready_low: assert property (@(posedge clk) disable iff (!rstN)
    uopValid |-> !inReady);

  // R3: the run ends right after its final element
  a_r3_run_ends: assert property (@(posedge clk) disable iff (!rstN)
    pcAdvance |=> (!uopValid && inReady));

  // R8: a stalled element stays presented
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && !uopReady) |=> uopValid);

endmodule

// File: rtl/tagSeqDatapath.sv
`timescale 1ns/1ps
module tagSeqDatapath
  import tagseq_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int OP_W     = 8,
  parameter int VL_W     = 8,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [OP_W-1:0]   inOp,
  input  logic [REG_W-1:0]  inRd,
  input  logic [REG_W-1:0]  inRs1,
  input  logic [REG_W-1:0]  inRs2,
  input  logic              csrWrEn,
  input  logic              csrWrKind,
  input  logic [REG_W-1:0]  csrWrIdx,
  input  logic [VL_W-1:0]   csrWrData,
  input  logic              uopValid,
  output logic [OP_W-1:0]   uopOp,
  output logic [REG_W-1:0]  uopRd,
  output logic [REG_W-1:0]  uopRs1,
  output logic [REG_W-1:0]  uopRs2,
  output logic              uopWrEn,
  output logic              uopHint,
  output logic [VL_W-1:0]   uopVl,
  output logic [VL_W-1:0]   uopIdx,
  output logic              uopLast,
  output logic              uopWrap,
  output logic              lastElem
);

  localparam int SUM_W = ((VL_W > REG_W) ? VL_W : REG_W) + 1;

  // Architectural CSR state
  logic [NUM_REGS-1:0] tagTable;
  logic [VL_W-1:0]     vlReg;

  // Snapshot of the accepted instruction
  logic [REG_W-1:0]        baseQ [NUM_OPERANDS];
  logic [NUM_OPERANDS-1:0] tagQ;
  logic [OP_W-1:0]         opQ;
  logic [VL_W-1:0]         vlQ;
  logic [VL_W-1:0]         countQ;
  logic [VL_W-1:0]         idxQ;

  logic [NUM_OPERANDS-1:0] tagLookup;
  logic [VL_W-1:0]         countD;

  always_comb begin
    tagLookup = {tagTable[inRs2], tagTable[inRs1], tagTable[inRd]};
    countD    = ((|tagLookup) && (vlReg > VL_W'(1))) ? vlReg : VL_W'(1);
  end

  // CSR port: only lands between instructions
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagTable <= '0;
      vlReg    <= VL_W'(1);
    end else if (csrWrEn && strobes.csrOpen) begin
      if (csrWrKind) vlReg <= csrWrData;
      else           tagTable[csrWrIdx] <= csrWrData[0];
    end
  end

  // Instruction capture and element counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_OPERANDS; k++) baseQ[k] <= '0;
      tagQ   <= '0;
      opQ    <= '0;
      vlQ    <= '0;
      countQ <= VL_W'(1);
      idxQ   <= '0;
    end else if (strobes.load) begin
      baseQ[0] <= inRd;
      baseQ[1] <= inRs1;
      baseQ[2] <= inRs2;
      tagQ     <= tagLookup;
      opQ      <= inOp;
      vlQ      <= vlReg;
      countQ   <= countD;
      idxQ     <= '0;
    end else if (strobes.step) begin
      idxQ <= idxQ + VL_W'(1);
    end
  end

  // Per-operand element register numbers
  logic [REG_W-1:0]        elemReg [NUM_OPERANDS];
  logic [NUM_OPERANDS-1:0] wrapVec;

  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : gOperand
    logic [SUM_W-1:0] sum;
    assign sum        = SUM_W'(baseQ[g]) + SUM_W'(idxQ);
    assign elemReg[g] = tagQ[g] ? sum[REG_W-1:0] : baseQ[g];
    assign wrapVec[g] = tagQ[g] && (sum >= SUM_W'(NUM_REGS));
  end

  logic rdIsZero;

  always_comb begin
    rdIsZero = (baseQ[0] == '0);
    lastElem = (idxQ == countQ - VL_W'(1));
    uopOp    = opQ;
    uopRd    = rdIsZero ? '0 : elemReg[0];
    uopRs1   = elemReg[1];
    uopRs2   = elemReg[2];
    uopHint  = rdIsZero;
    uopWrEn  = !rdIsZero;
    uopVl    = vlQ;
    uopIdx   = idxQ;
    uopLast  = uopValid && lastElem;
    uopWrap  = (wrapVec[0] && !rdIsZero) || wrapVec[1] || wrapVec[2];
  end

  // R9: tags and length stay frozen while a run is in progress
  a_r9_csr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.csrOpen |=> ($stable(tagTable) && $stable(vlReg)));

  // R8: the index moves by exactly one per non-final handshake
  a_r8_idx_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (uopIdx == $past(uopIdx) + VL_W'(1)));

  // R5: an untagged source does not move between elements
  a_r5_untagged_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !tagQ[1] && !tagQ[2]) |=> ($stable(uopRs1) && $stable(uopRs2)));

  // R7: hint elements never carry a nonzero destination
  a_r7_hint_rd: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && uopHint) |-> (uopRd == '0 && !uopWrEn));

endmodule

// File: rtl/tagIssueSeq.sv
`timescale 1ns/1ps
module tagIssueSeq
  import tagseq_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int OP_W     = 8,
  parameter int VL_W     = 8,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [OP_W-1:0]   inOp,
  input  logic [REG_W-1:0]  inRd,
  input  logic [REG_W-1:0]  inRs1,
  input  logic [REG_W-1:0]  inRs2,
  input  logic              csrWrEn,
  input  logic              csrWrKind,
  input  logic [REG_W-1:0]  csrWrIdx,
  input  logic [VL_W-1:0]   csrWrData,
  output logic              uopValid,
  input  logic              uopReady,
  output logic [OP_W-1:0]   uopOp,
  output logic [REG_W-1:0]  uopRd,
  output logic [REG_W-1:0]  uopRs1,
  output logic [REG_W-1:0]  uopRs2,
  output logic              uopWrEn,
  output logic              uopHint,
  output logic [VL_W-1:0]   uopVl,
  output logic [VL_W-1:0]   uopIdx,
  output logic              uopLast,
  output logic              uopWrap,
  output logic              pcAdvance
);

  seqStrobes_t strobes;
  logic        lastElem;

  tagSeqCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .uopReady  (uopReady),
    .lastElem  (lastElem),
    .inReady   (inReady),
    .uopValid  (uopValid),
    .pcAdvance (pcAdvance),
    .strobes   (strobes)
  );

  tagSeqDatapath #(
    .NUM_REGS (NUM_REGS),
    .OP_W     (OP_W),
    .VL_W     (VL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inOp      (inOp),
    .inRd      (inRd),
    .inRs1     (inRs1),
    .inRs2     (inRs2),
    .csrWrEn   (csrWrEn),
    .csrWrKind (csrWrKind),
    .csrWrIdx  (csrWrIdx),
    .csrWrData (csrWrData),
    .uopValid  (uopValid),
    .uopOp     (uopOp),
    .uopRd     (uopRd),
    .uopRs1    (uopRs1),
    .uopRs2    (uopRs2),
    .uopWrEn   (uopWrEn),
    .uopHint   (uopHint),
    .uopVl     (uopVl),
    .uopIdx    (uopIdx),
    .uopLast   (uopLast),
    .uopWrap   (uopWrap),
    .lastElem  (lastElem)
  );

endmodule

// File: tb/tagIssueSeq_tb.sv
`timescale 1ns/1ps
module tagIssueSeq_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] inOp = '0;
  logic [4:0] inRd = '0, inRs1 = '0, inRs2 = '0;
  logic       csrWrEn = 1'b0, csrWrKind = 1'b0;
  logic [4:0] csrWrIdx = '0;
  logic [7:0] csrWrData = '0;
  logic       uopValid;
  logic       uopReady = 1'b1;
  logic [7:0] uopOp;
  logic [4:0] uopRd, uopRs1, uopRs2;
  logic       uopWrEn, uopHint;
  logic [7:0] uopVl, uopIdx;
  logic       uopLast, uopWrap, pcAdvance;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tagIssueSeq u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inOp(inOp), .inRd(inRd), .inRs1(inRs1), .inRs2(inRs2),
    .csrWrEn(csrWrEn), .csrWrKind(csrWrKind), .csrWrIdx(csrWrIdx),
    .csrWrData(csrWrData), .uopValid(uopValid), .uopReady(uopReady),
    .uopOp(uopOp), .uopRd(uopRd), .uopRs1(uopRs1), .uopRs2(uopRs2),
    .uopWrEn(uopWrEn), .uopHint(uopHint), .uopVl(uopVl), .uopIdx(uopIdx),
    .uopLast(uopLast), .uopWrap(uopWrap), .pcAdvance(pcAdvance)
  );

  typedef struct packed {
    logic [7:0] vl;
    logic       tR, t1, t2;
    logic [4:0] rd, rs1, rs2;
    logic [7:0] stall;
    logic [7:0] op;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd5, 1'b0, 1'b0, 1'b0, 5'd3,  5'd4,  5'd5,  8'h00, 8'h11},  // no tags
    '{8'd4, 1'b0, 1'b1, 1'b0, 5'd7,  5'd10, 5'd12, 8'h00, 8'h22},  // rs1 only
    '{8'd3, 1'b1, 1'b0, 1'b1, 5'd20, 5'd2,  5'd8,  8'h05, 8'h33},  // rd+rs2
    '{8'd4, 1'b0, 1'b1, 1'b0, 5'd6,  5'd30, 5'd9,  8'h02, 8'h44},  // rs1 wraps
    '{8'd3, 1'b0, 1'b1, 1'b0, 5'd0,  5'd16, 5'd1,  8'h00, 8'h55},  // hint
    '{8'd0, 1'b0, 1'b1, 1'b0, 5'd9,  5'd5,  5'd6,  8'h00, 8'h66},  // VL 0
    '{8'd1, 1'b1, 1'b1, 1'b1, 5'd13, 5'd14, 5'd15, 8'h00, 8'h77},  // VL 1
    '{8'd6, 1'b1, 1'b1, 1'b1, 5'd28, 5'd11, 5'd27, 8'hAA, 8'h88}   // all, wraps
  };

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic csrWrite(input logic kind, input logic [4:0] idx, input logic [7:0] data);
    @(negedge clk);
    csrWrEn = 1'b1; csrWrKind = kind; csrWrIdx = idx; csrWrData = data;
    @(negedge clk);
    csrWrEn = 1'b0;
  endtask

  function automatic logic [4:0] expReg(input logic [4:0] base, input logic tag, input int i);
    return tag ? 5'((int'(base) + i) % 32) : base;
  endfunction

  // Issue one instruction and follow every element it produces.
  // tR/t1/t2 are the tags the bench has set up; vl is the length in force.
  task automatic runInstr(input logic [7:0] vl, input logic tR, input logic t1, input logic t2,
                          input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2,
                          input logic [7:0] stall, input logic [7:0] op, input bit midWrite);
    int n = ((tR || t1 || t2) && vl > 1) ? int'(vl) : 1;
    int got = 0;
    int cyc = 0;
    @(negedge clk);
    inValid = 1'b1; inOp = op; inRd = rd; inRs1 = rs1; inRs2 = rs2;
    #0.5;
    chk("R8 inReady high before accept", int'(inReady), 1);
    @(posedge clk);
    #0.5;
    inValid = 1'b0;
    while (got < n && cyc < 400) begin
      @(negedge clk);
      uopReady = !stall[cyc % 8];
      if (midWrite && cyc == 1) begin
        csrWrEn = 1'b1; csrWrKind = 1'b1; csrWrIdx = '0; csrWrData = 8'd9;
      end else begin
        csrWrEn = 1'b0;
      end
      cyc++;
      #0.5;
      chk("R3 uopValid during run", int'(uopValid), 1);
      chk("R8 inReady low during run", int'(inReady), 0);
      if (uopReady) begin
        logic [4:0] eRd;
        bit eWrap;
        eRd = (rd == 0) ? 5'd0 : expReg(rd, tR, got);
        eWrap = (tR && rd != 0 && int'(rd) + got > 31) ||
                (t1 && int'(rs1) + got > 31) || (t2 && int'(rs2) + got > 31);
        chk("R8 element index", int'(uopIdx), got);
        chk("R4 R5 element rd", int'(uopRd), int'(eRd));
        chk("R4 R5 element rs1", int'(uopRs1), int'(expReg(rs1, t1, got)));
        chk("R4 R5 element rs2", int'(uopRs2), int'(expReg(rs2, t2, got)));
        chk("R7 hint flag", int'(uopHint), (rd == 0) ? 1 : 0);
        chk("R7 write enable", int'(uopWrEn), (rd == 0) ? 0 : 1);
        chk("R7 VL attached", int'(uopVl), int'(vl));
        chk("R7 op passed", int'(uopOp), int'(op));
        chk("R10 wrap flag", int'(uopWrap), eWrap ? 1 : 0);
        chk("R2 R3 last flag", int'(uopLast), (got == n - 1) ? 1 : 0);
        chk("R6 pcAdvance on handshake", int'(pcAdvance), (got == n - 1) ? 1 : 0);
        got++;
      end else begin
        chk("R6 no pcAdvance while stalled", int'(pcAdvance), 0);
      end
    end
    @(negedge clk);
    csrWrEn = 1'b0;
    uopReady = 1'b1;
    #0.5;
    chk("R2 R3 element count reached, run over", int'(uopValid), 0);
    chk("R8 inReady back after run", int'(inReady), 1);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #0.5;
    // R11 reset outputs
    chk("R11 inReady after reset", int'(inReady), 1);
    chk("R11 uopValid after reset", int'(uopValid), 0);
    chk("R11 pcAdvance after reset", int'(pcAdvance), 0);

    // R1 reset defaults: tags clear, VL = 1 -> single element with uopVl 1
    runInstr(8'd1, 1'b0, 1'b0, 1'b0, 5'd2, 5'd3, 5'd4, 8'h00, 8'h01, 1'b0);

    // Table of vectors (R1..R8, R10)
    for (int v = 0; v < NV; v++) begin
      csrWrite(1'b1, 5'd0, VECS[v].vl);
      csrWrite(1'b0, VECS[v].rd,  {7'd0, VECS[v].tR});
      csrWrite(1'b0, VECS[v].rs1, {7'd0, VECS[v].t1});
      csrWrite(1'b0, VECS[v].rs2, {7'd0, VECS[v].t2});
      runInstr(VECS[v].vl, VECS[v].tR, VECS[v].t1, VECS[v].t2,
               VECS[v].rd, VECS[v].rs1, VECS[v].rs2, VECS[v].stall, VECS[v].op, 1'b0);
      csrWrite(1'b0, VECS[v].rd,  8'd0);
      csrWrite(1'b0, VECS[v].rs1, 8'd0);
      csrWrite(1'b0, VECS[v].rs2, 8'd0);
    end

    // R9: a VL write during a run is dropped; the next run still uses VL 3
    csrWrite(1'b1, 5'd0, 8'd3);
    csrWrite(1'b0, 5'd4, 8'd1);
    runInstr(8'd3, 1'b0, 1'b1, 1'b0, 5'd1, 5'd4, 5'd2, 8'h06, 8'h9A, 1'b1);
    runInstr(8'd3, 1'b0, 1'b1, 1'b0, 5'd1, 5'd4, 5'd2, 8'h00, 8'h9B, 1'b0);

    // R1: clearing the tag returns to single issue
    csrWrite(1'b0, 5'd4, 8'd0);
    runInstr(8'd3, 1'b0, 1'b0, 1'b0, 5'd1, 5'd4, 5'd2, 8'h00, 8'h9C, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule